// File: doc/BRIEF.md
# Marker-Channel Frame Aligner

This block sits behind a converter that scans four analog inputs in a fixed round-robin loop with no end. Three of the scan slots carry three-axis sensor data. The fourth input is tied above the converter's valid range, so in that slot the sample always has the maximum code. No channel number or frame signal comes with the samples. The aligner uses that saturated slot as a frame marker and assigns the three samples after it to axis 0, axis 1 and axis 2.

While it is searching, the block counts the valid samples modulo the scan length. It accepts a slot as the marker only when the full-scale code appears at that slot position on consecutive scans. This keeps a single saturated data reading from being taken as the marker. Once locked, it checks that the marker is still present on every scan. Every full-scale reading in a data slot is passed on as ordinary saturated data. A missing marker causes a one-cycle error pulse, loss of lock and a new search. Each complete frame is presented on one wide output bus with a single-cycle strobe, and the bus holds its value until the next frame.

Top module: `mkr_frame_aligner`

## Requirements
- R1: During and right after the synchronous active-low reset, `locked`, `frm_valid` and `sync_err` are 0 and `frm_axis` is all zeros.
- R2: While searching, the block locks when the full-scale code 0xFFFF arrives at the same slot position (counted in valid samples modulo 4) on two consecutive scans. `locked` goes high on the clock edge that accepts the second such sample.
- R3: A full-scale sample that is not repeated at the same slot position on the next scan does not cause lock, and neither does a full-scale sample at a different slot position.
- R4: While locked, the three valid samples after a marker go, in order, to axis 0, 1 and 2. Axis k occupies `frm_axis[16k+15:16k]`, and the whole frame is loaded on the edge that accepts the third data sample.
- R5: `frm_valid` is high for exactly one cycle per frame, in the cycle after the third data sample is accepted. `frm_axis` does not change between frames.
- R6: Cycles with `smp_valid` low are ignored. They do not advance the slot position, do not change any output and do not produce a frame.
- R7: While locked, a data slot that reads 0xFFFF is output as axis data unchanged, and lock is kept.
- R8: While locked, a marker-slot sample other than 0xFFFF raises `sync_err` for one cycle and clears `locked` on the same edge. The block must then see two fresh consecutive marker hits before it locks again.
- R9: Asserting reset while locked clears lock and the slot position. Locking again needs two consecutive marker hits counted from the first sample after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe, one sample per high cycle |
| smp_data | input | 16 | Converter sample |
| frm_valid | output | 1 | One-cycle strobe for a new frame |
| frm_axis | output | 48 | Frame data, axis k at bits 16k+15:16k |
| locked | output | 1 | Marker slot found and being tracked |
| sync_err | output | 1 | One-cycle pulse when the expected marker is missing |

## Verification
Every output comes from a register one edge after the sample that causes it. `locked` rises and `sync_err` pulses one edge after the deciding marker sample, and `frm_valid` together with the new `frm_axis` value appear one edge after the third data sample. The bench drives each sample on a falling edge and holds it for one cycle. It then reads the outputs on the next falling edge, after the edge that accepted the sample, so each check falls in the exact cycle in which its result is due. Idle cycles are inserted between samples to show that the timing follows accepted samples and not clock count.

// File: rtl/mfa_pkg.sv
// Shared types for the marker-channel frame aligner.
// Assumes nothing beyond a standard SystemVerilog package scope.
package mfa_pkg;

    // Alignment state of the tracker
    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } mfa_state_e;

endpackage

// File: rtl/mfa_marker_det.sv
// Flags a valid sample that carries the all-ones (full-scale) code.
// Assumes the marker channel saturates to every bit set.
module mfa_marker_det #(
    parameter int W = 16
) (
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    output logic         hit
);

    // Full-scale compare, qualified by the sample strobe
    always_comb begin
        hit = smp_valid && (&smp_data);
    end

endmodule

// File: rtl/mfa_lock_fsm.sv
// Finds the marker slot and tracks it. While searching, it keeps a
// run counter for each slot position and locks when one slot position
// has shown full scale on CONFIRM consecutive scans. While locked, it
// keeps a phase counter (0 = marker) and steers data samples to axis
// indices. A missing marker gives a one-cycle error and a new search.
// Assumes N_SLOTS >= 3 and CONFIRM >= 1.
module mfa_lock_fsm
    import mfa_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int CONFIRM = 2,
    localparam int N_AXES = N_SLOTS - 1,
    localparam int PW     = (N_SLOTS > 2) ? $clog2(N_SLOTS) : 1,
    localparam int IW     = (N_AXES > 1) ? $clog2(N_AXES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic          hit,
    output logic          locked,
    output logic          sync_err,
    output logic          dat_we,
    output logic [IW-1:0] dat_idx
);

    localparam int CW = $clog2(CONFIRM + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(CONFIRM - 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(CONFIRM);
    localparam logic [PW-1:0] SLOT_END = PW'(N_SLOTS - 1);

    mfa_state_e    st;
    logic [PW-1:0] pos;
    logic [PW-1:0] phase;
    logic [CW-1:0] run [N_SLOTS];
    logic          lock_now;
    logic          err_now;
    logic          clr_run;

    // Decide this cycle's lock, error and data-steer events
    always_comb begin
        lock_now = (st == ST_SEARCH) && hit && (run[pos] == CNT_LAST);
        err_now  = (st == ST_LOCKED) && smp_valid && (phase == '0) && !hit;
        clr_run  = lock_now || err_now;
        dat_we   = (st == ST_LOCKED) && smp_valid && (phase != '0);
        dat_idx  = IW'(phase - 1'b1);
    end

    // Per-slot run counters of consecutive full-scale readings
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_run
        always_ff @(posedge clk) begin
            if (!rst_n || clr_run) begin
                run[g] <= '0;
            end else if (smp_valid && (st == ST_SEARCH) && (pos == PW'(g))) begin
                if (!hit)
                    run[g] <= '0;
                else if (run[g] != CNT_TOP)
                    run[g] <= run[g] + 1'b1;
            end
        end
    end

    // Slot position over valid samples, modulo the scan length
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (smp_valid)
            pos <= (pos == SLOT_END) ? '0 : pos + 1'b1;
    end

    // Search/locked state and phase relative to the marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_SEARCH;
            phase <= '0;
        end else if (lock_now) begin
            st    <= ST_LOCKED;
            phase <= PW'(1);
        end else if (err_now) begin
            st    <= ST_SEARCH;
            phase <= '0;
        end else if ((st == ST_LOCKED) && smp_valid) begin
            phase <= (phase == SLOT_END) ? '0 : phase + 1'b1;
        end
    end

    // One-cycle error pulse for a missing marker
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_err <= 1'b0;
        else
            sync_err <= err_now;
    end

    // Lock flag presented at the port
    always_comb begin
        locked = (st == ST_LOCKED);
    end

endmodule

// File: rtl/mfa_frame_asm.sv
// Collects the steered data samples into a frame. The first N_AXES-1
// samples wait in holding registers. The last one loads the whole
// output bus at once and raises a one-cycle strobe, so the bus only
// changes at a frame boundary. Assumes N_AXES >= 2.
module mfa_frame_asm #(
    parameter int W      = 16,
    parameter int N_AXES = 3,
    localparam int IW    = (N_AXES > 1) ? $clog2(N_AXES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dat_we,
    input  logic [IW-1:0]       dat_idx,
    input  logic [W-1:0]        smp_data,
    output logic                frm_valid,
    output logic [N_AXES*W-1:0] frm_axis
);

    localparam logic [IW-1:0] IDX_LAST = IW'(N_AXES - 1);

    logic [W-1:0] hold [N_AXES-1];
    logic         last_we;

    // Detect the sample that completes the frame
    always_comb begin
        last_we = dat_we && (dat_idx == IDX_LAST);
    end

    // Holding registers for the leading axes
    for (genvar k = 0; k < N_AXES - 1; k++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold[k] <= '0;
            else if (dat_we && (dat_idx == IW'(k)))
                hold[k] <= smp_data;
        end
    end

    // Output bus, loaded in one step when the frame completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_axis <= '0;
        end else if (last_we) begin
            for (int k = 0; k < N_AXES - 1; k++)
                frm_axis[k*W +: W] <= hold[k];
            frm_axis[(N_AXES-1)*W +: W] <= smp_data;
        end
    end

    // Single-cycle frame strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            frm_valid <= 1'b0;
        else
            frm_valid <= last_we;
    end

endmodule

// File: rtl/mkr_frame_aligner.sv
// Top of the marker-channel frame aligner. It takes a round-robin
// stream of converter samples in which one slot is held at full scale,
// finds that slot and outputs aligned multi-axis frames.
// Assumes samples arrive in a fixed slot order and never skip a slot.
module mkr_frame_aligner #(
    parameter int SMP_W   = 16,
    parameter int N_SLOTS = 4,
    parameter int CONFIRM = 2,
    localparam int N_AXES = N_SLOTS - 1,
    localparam int IW     = (N_AXES > 1) ? $clog2(N_AXES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [SMP_W-1:0]        smp_data,
    output logic                    frm_valid,
    output logic [N_AXES*SMP_W-1:0] frm_axis,
    output logic                    locked,
    output logic                    sync_err
);

    logic          hit;
    logic          dat_we;
    logic [IW-1:0] dat_idx;

    mfa_marker_det #(.W(SMP_W)) u_det (
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .hit       (hit)
    );

    mfa_lock_fsm #(.N_SLOTS(N_SLOTS), .CONFIRM(CONFIRM)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .hit       (hit),
        .locked    (locked),
        .sync_err  (sync_err),
        .dat_we    (dat_we),
        .dat_idx   (dat_idx)
    );

    mfa_frame_asm #(.W(SMP_W), .N_AXES(N_AXES)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dat_we    (dat_we),
        .dat_idx   (dat_idx),
        .smp_data  (smp_data),
        .frm_valid (frm_valid),
        .frm_axis  (frm_axis)
    );

endmodule

// File: rtl/mfa_checker.sv
// Timing properties of the aligner, checked at its ports.
// Assumes the defaults of the top module or any legal override.
module mfa_checker #(
    parameter int SMP_W  = 16,
    parameter int N_AXES = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_valid,
    input logic [SMP_W-1:0]        smp_data,
    input logic                    frm_valid,
    input logic [N_AXES*SMP_W-1:0] frm_axis,
    input logic                    locked,
    input logic                    sync_err
);

    AST_LOCK_ON_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(smp_valid && (&smp_data)));  // R2

    AST_FRM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);  // R5

    AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |-> $stable(frm_axis));  // R5

    AST_FRM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> locked);  // R4

    AST_IDLE_NO_FRM: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !frm_valid && !sync_err);  // R6

    AST_ERR_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> !locked && $past(locked));  // R8

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> $past(smp_valid && !(&smp_data)));  // R8

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> !sync_err);  // R8

endmodule

bind mkr_frame_aligner mfa_checker #(.SMP_W(SMP_W), .N_AXES(N_AXES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .frm_valid (frm_valid),
    .frm_axis  (frm_axis),
    .locked    (locked),
    .sync_err  (sync_err)
);

// File: tb/sim_mkr_frame_aligner.sv
module sim_mkr_frame_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        frm_valid;
    logic [47:0] frm_axis;
    logic        locked;
    logic        sync_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [15:0] MK = 16'hFFFF;

    always #5 clk = ~clk;

    mkr_frame_aligner u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .frm_valid (frm_valid),
        .frm_axis  (frm_axis),
        .locked    (locked),
        .sync_err  (sync_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one valid sample, ending on the falling edge after its capture edge
    task automatic push(input logic [15:0] d);
        smp_valid = 1'b1;
        smp_data  = d;
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data  = 16'h0BAD;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp_valid = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    // marker then three data samples, checking the frame at the end
    task automatic scan(input logic [15:0] a0, a1, a2, input bit expect_frm, input string tag);
        push(MK);
        push(a0);
        push(a1);
        push(a2);
        if (expect_frm) begin
            chk({tag, " frm_valid"}, 64'(frm_valid), 64'd1);
            chk({tag, " frm_axis"}, 64'(frm_axis), 64'({a2, a1, a0}));
        end
    endtask

    task automatic get_lock();
        do_reset();
        push(16'h0100);
        scan(16'h0001, 16'h0002, 16'h0003, 1'b0, "");
        push(MK);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 locked", 64'(locked), 64'd0);
        chk("R1 frm_valid", 64'(frm_valid), 64'd0);
        chk("R1 sync_err", 64'(sync_err), 64'd0);
        chk("R1 frm_axis", 64'(frm_axis), 64'd0);
    endtask

    task automatic t_lock();
        do_reset();
        push(16'h1111);
        push(16'h2222);
        push(MK);
        chk("R2 first hit no lock", 64'(locked), 64'd0);
        push(16'h0A00);
        push(16'h0B00);
        push(16'h0C00);
        push(MK);
        chk("R2 locked after second hit", 64'(locked), 64'd1);
        push(16'h1234);
        push(16'h5678);
        chk("R5 no strobe mid frame", 64'(frm_valid), 64'd0);
        push(16'h9ABC);
        chk("R4 strobe", 64'(frm_valid), 64'd1);
        chk("R4 axis order", 64'(frm_axis), 64'h9ABC_5678_1234);
        push(MK);
        chk("R5 strobe one cycle", 64'(frm_valid), 64'd0);
        chk("R5 axis held", 64'(frm_axis), 64'h9ABC_5678_1234);
        push(16'h0011);
        chk("R5 axis held mid frame", 64'(frm_axis), 64'h9ABC_5678_1234);
        push(16'h0022);
        push(16'h0033);
        chk("R4 second frame", 64'(frm_axis), 64'h0033_0022_0011);
    endtask

    task automatic t_single();
        do_reset();
        push(MK);
        for (int i = 0; i < 7; i++) push(16'(16'h0200 + i));
        chk("R3 lone max no lock", 64'(locked), 64'd0);
        push(16'h0300);
        push(MK);
        push(16'h0301);
        push(16'h0302);
        push(16'h0303);
        push(16'h0304);
        push(MK);
        chk("R3 shifted slot no lock", 64'(locked), 64'd0);
    endtask

    task automatic t_idle();
        get_lock();
        push(16'h4001);
        idle(3);
        chk("R6 no strobe during idle", 64'(frm_valid), 64'd0);
        push(16'h4002);
        idle(2);
        push(16'h4003);
        chk("R6 frame after gaps", 64'(frm_axis), 64'h4003_4002_4001);
        idle(4);
        chk("R6 lock kept through idle", 64'(locked), 64'd1);
        scan(16'h4011, 16'h4012, 16'h4013, 1'b1, "R6 aligned after gaps");
    endtask

    task automatic t_sat();
        get_lock();
        push(16'h5001);
        push(MK);
        push(16'h5003);
        chk("R7 saturated data frame", 64'(frm_axis), 64'h5003_FFFF_5001);
        chk("R7 lock kept", 64'(locked), 64'd1);
        scan(MK, MK, 16'h5004, 1'b1, "R7 two saturated axes");
        chk("R7 lock still kept", 64'(locked), 64'd1);
    endtask

    task automatic t_err();
        get_lock();
        push(16'h6001);
        push(16'h6002);
        push(16'h6003);
        push(16'h1234);
        chk("R8 sync_err", 64'(sync_err), 64'd1);
        chk("R8 lock dropped", 64'(locked), 64'd0);
        push(16'h6011);
        chk("R8 sync_err one cycle", 64'(sync_err), 64'd0);
        push(16'h6012);
        push(16'h6013);
        push(MK);
        chk("R8 no instant relock", 64'(locked), 64'd0);
        push(16'h6021);
        push(16'h6022);
        push(16'h6023);
        push(MK);
        chk("R8 relock", 64'(locked), 64'd1);
        push(16'h6031);
        push(16'h6032);
        push(16'h6033);
        chk("R8 frame after relock", 64'(frm_axis), 64'h6033_6032_6031);
    endtask

    task automatic t_rst();
        get_lock();
        push(16'h7001);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        chk("R9 lock cleared", 64'(locked), 64'd0);
        push(MK);
        push(16'h7011);
        push(16'h7012);
        push(16'h7013);
        chk("R9 no frame before relock", 64'(frm_valid), 64'd0);
        push(MK);
        chk("R9 relock from slot 0", 64'(locked), 64'd1);
        push(16'h7021);
        push(16'h7022);
        push(16'h7023);
        chk("R9 frame after reset", 64'(frm_axis), 64'h7023_7022_7021);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_lock();
        t_single();
        t_idle();
        t_sat();
        t_err();
        t_rst();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule